// File: doc/BRIEF.md
# Gapped-Clock Sync Recovery and Timestamp Counter

This block sits on the receiving end of a distributed reference clock, nominally 48 MHz, from which a single pulse is left out at regular intervals (about every 10 ms) to mark a common sync instant across several nodes. The block runs on a faster local clock and oversamples the incoming line. It measures the spacing between rising edges in local ticks, and it treats one missing pulse as a sync event. From these events it keeps a two-part timestamp: a fine count of received edges since the last sync, and a count of sync events seen.

A mode input can replace gap-derived sync with an internal sync timer. The timer period is programmable and defaults to 170 µs of local clock. A capture strobe freezes both counters together. A small address-decoded read port returns the live sync count and the captured pair. Software can read the sync count before and after a sync to confirm that this node saw the event. When syncs come often, software can use the fine count alone.

Two consecutive missing pulses mean the clock was lost, not that a sync arrived. The block flags this and leaves its counters unchanged.

Top module: `gapClockTimestamp`

## Requirements
- R1: After reset the first rising edge of `rxClk` only arms the block. Each later ordinary edge (spacing at most 1.5 nominal periods) raises `fineCnt` by exactly one.
- R2: In gap mode (`modeSel`=0), an edge that ends a spacing of more than 1.5 and at most 2.5 nominal periods is a sync. On that edge `fineCnt` goes to 0, `syncCnt` rises by one, and `syncStb` is high for one cycle.
- R3: `syncCnt` counts modulo 2^SYNC_W. It wraps from all ones to zero, and it changes only on a sync.
- R4: While more than 2.5 nominal periods have passed since the last edge, `clkLoss` is high. The edge that ends such a silence changes neither counter, raises no `syncStb`, and clears `clkLoss`.
- R5: A one-cycle `capStb` copies `fineCnt` and `syncCnt` in the same cycle. The copies hold until the next capture.
- R6: `rdData` is combinational on `rdAddr`, zero-extended. Address 0 returns the live sync count, 1 the captured fine count, 2 the captured sync count, and 3 reads zero.
- R7: In timer mode (`modeSel`=1), gaps count as ordinary edges. A sync (as in R2) is applied at the first accepted edge after each timer expiry. The timer expires every `timerPeriod` local cycles, counted from the cycle the mode was entered.
- R8: `timerPeriod`=0 selects the default period of OVS×48×170 local cycles (65280 with defaults).
- R9: Reset clears both counters, both captured values and `clkLoss`. `syncStb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oversampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxClk | input | 1 | Incoming gapped clock, asynchronous |
| modeSel | input | 1 | 0 = sync from gaps, 1 = sync from internal timer |
| timerPeriod | input | TIMER_W | Timer period in local cycles, 0 = default |
| capStb | input | 1 | Capture both counters |
| rdAddr | input | 2 | Read port address |
| rdData | output | DATA_W | Read port data |
| fineCnt | output | FINE_W | Live fine edge count |
| syncCnt | output | SYNC_W | Live sync event count |
| syncStb | output | 1 | One-cycle sync marker, counters update on the next edge of `clk` |
| clkLoss | output | 1 | Incoming clock absent for over 2.5 periods |

## Verification
A wrong spacing measurement shows up on the very edge that closes a gap or silence. Either `syncStb` fires where none was expected, or it is missing. Within two local cycles `syncCnt` and `fineCnt` then disagree with the count of pulses sent. Counter faults persist, so every later read of the live or captured values exposes them. A timer fault shows up as a sync count that is off after a known number of timer periods.

// File: rtl/tsRx_pkg.sv
package tsRx_pkg;
  typedef struct packed {
    logic fineInc;
    logic fineClr;
    logic syncInc;
    logic capture;
  } tsStrobe_t;
endpackage

// File: rtl/gapSyncCtrl.sv
module gapSyncCtrl
  import tsRx_pkg::*;
#(
  parameter int OVS         = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TIMER_W     = 20,
  parameter int TIMER_DEF   = 65280
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxClk,
  input  logic               modeSel,
  input  logic [TIMER_W-1:0] timerPeriod,
  input  logic               capStb,
  output tsStrobe_t          strb,
  output logic               syncStb,
  output logic               clkLoss
);
  localparam int GAP_T   = (OVS * 3) / 2;
  localparam int LOSS_T  = (OVS * 5) / 2;
  localparam int SPACE_W = $clog2(LOSS_T + 2) + 1;
  localparam logic [SPACE_W-1:0] SPACE_MAX = '1;

  logic [SYNC_STAGES:0] rxPipe;
  logic                 rxEdge;
  logic [SPACE_W-1:0]   spaceCnt;
  logic                 primed;
  logic                 isLoss, isGap, edgeOk, doSync;
  logic [TIMER_W-1:0]   timerCnt, periodEff;
  logic                 timerTick, pend;

  // Synchronizer plus one delayed stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) rxPipe <= '0;
    else       rxPipe <= {rxPipe[SYNC_STAGES-1:0], rxClk};
  end
  assign rxEdge = rxPipe[SYNC_STAGES-1] & ~rxPipe[SYNC_STAGES];

  // Ticks since the previous accepted rising edge, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      spaceCnt <= '0;
      primed   <= 1'b0;
    end else if (rxEdge) begin
      spaceCnt <= SPACE_W'(1);
      primed   <= 1'b1;
    end else if (spaceCnt != SPACE_MAX) begin
      spaceCnt <= spaceCnt + 1'b1;
    end
  end

  assign isLoss  = spaceCnt > SPACE_W'(LOSS_T);
  assign isGap   = (spaceCnt > SPACE_W'(GAP_T)) && !isLoss;
  assign clkLoss = primed && isLoss;

  // Internal sync timer, restarted whenever timer mode is left
  assign periodEff = (timerPeriod == '0) ? TIMER_W'(TIMER_DEF) : timerPeriod;
  assign timerTick = modeSel && (timerCnt == periodEff - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN || !modeSel) timerCnt <= '0;
    else if (timerTick)    timerCnt <= '0;
    else                   timerCnt <= timerCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !modeSel)         pend <= 1'b0;
    else if (timerTick)            pend <= 1'b1;
    else if (edgeOk && pend)       pend <= 1'b0;
  end

  assign edgeOk = rxEdge && primed && !isLoss;
  assign doSync = edgeOk && (modeSel ? pend : isGap);

  always_comb begin
    strb.fineInc = edgeOk && !doSync;
    strb.fineClr = doSync;
    strb.syncInc = doSync;
    strb.capture = capStb;
  end
  assign syncStb = doSync;

  assert_one_action_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.fineInc, strb.fineClr}));

  assert_loss_no_sync_R4: assert property (@(posedge clk) disable iff (!rstN)
    clkLoss |-> !syncStb && !strb.fineInc);

  assert_timer_mode_gap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel && !pend) |-> !syncStb);

endmodule

// File: rtl/tsDatapath.sv
module tsDatapath
  import tsRx_pkg::*;
#(
  parameter int FINE_W = 20,
  parameter int SYNC_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tsStrobe_t         strb,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [FINE_W-1:0] fineCnt,
  output logic [SYNC_W-1:0] syncCnt
);
  logic [FINE_W-1:0] capFine;
  logic [SYNC_W-1:0] capSync;

  always_ff @(posedge clk) begin
    if (!rstN)             fineCnt <= '0;
    else if (strb.fineClr) fineCnt <= '0;
    else if (strb.fineInc) fineCnt <= fineCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             syncCnt <= '0;
    else if (strb.syncInc) syncCnt <= syncCnt + 1'b1;
  end

  // Both copies load from the same register state in one cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capFine <= '0;
      capSync <= '0;
    end else if (strb.capture) begin
      capFine <= fineCnt;
      capSync <= syncCnt;
    end
  end

  always_comb begin
    case (rdAddr)
      2'd0:    rdData = DATA_W'(syncCnt);
      2'd1:    rdData = DATA_W'(capFine);
      2'd2:    rdData = DATA_W'(capSync);
      default: rdData = '0;
    endcase
  end

  assert_fine_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.fineClr |=> fineCnt == '0);

  assert_sync_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.syncInc |=> $stable(syncCnt));

  assert_sync_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.syncInc |=> syncCnt == SYNC_W'($past(syncCnt) + 1'b1));

  assert_cap_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(capFine) && $stable(capSync));

endmodule

// File: rtl/gapClockTimestamp.sv
module gapClockTimestamp
  import tsRx_pkg::*;
#(
  parameter int OVS         = 8,
  parameter int RX_MHZ      = 48,
  parameter int TIMER_US    = 170,
  parameter int SYNC_STAGES = 2,
  parameter int TIMER_W     = 20,
  parameter int FINE_W      = 20,
  parameter int SYNC_W      = 16,
  parameter int DATA_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxClk,
  input  logic               modeSel,
  input  logic [TIMER_W-1:0] timerPeriod,
  input  logic               capStb,
  input  logic [1:0]         rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [FINE_W-1:0]  fineCnt,
  output logic [SYNC_W-1:0]  syncCnt,
  output logic               syncStb,
  output logic               clkLoss
);
  localparam int TIMER_DEF = OVS * RX_MHZ * TIMER_US;

  tsStrobe_t strb;

  gapSyncCtrl #(
    .OVS(OVS), .SYNC_STAGES(SYNC_STAGES), .TIMER_W(TIMER_W), .TIMER_DEF(TIMER_DEF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rxClk(rxClk), .modeSel(modeSel),
    .timerPeriod(timerPeriod), .capStb(capStb), .strb(strb),
    .syncStb(syncStb), .clkLoss(clkLoss)
  );

  tsDatapath #(
    .FINE_W(FINE_W), .SYNC_W(SYNC_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr),
    .rdData(rdData), .fineCnt(fineCnt), .syncCnt(syncCnt)
  );

endmodule

// File: tb/gapClockTimestamp_tb.sv
module gapClockTimestamp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 8;
  localparam int SW         = 4;
  localparam int FW         = 20;
  localparam int TW         = 20;
  localparam int DW         = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxClk = 1'b0;
  logic          modeSel = 1'b0;
  logic [TW-1:0] timerPeriod = '0;
  logic          capStb = 1'b0;
  logic [1:0]    rdAddr = 2'd0;
  logic [DW-1:0] rdData;
  logic [FW-1:0] fineCnt;
  logic [SW-1:0] syncCnt;
  logic          syncStb, clkLoss;

  int nChecks = 0;
  int nFails  = 0;
  int expSync = 0;
  int expQ[$];
  bit chkPending = 1'b0;
  int chkVal = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gapClockTimestamp #(.OVS(OVS), .SYNC_W(SW), .FINE_W(FW), .TIMER_W(TW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .rxClk(rxClk), .modeSel(modeSel), .timerPeriod(timerPeriod),
    .capStb(capStb), .rdAddr(rdAddr), .rdData(rdData), .fineCnt(fineCnt),
    .syncCnt(syncCnt), .syncStb(syncStb), .clkLoss(clkLoss)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // Driver: one nominal rxClk period, half high and half low
  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rxClk = 1'b1;
      repeat (OVS/2) @(negedge clk);
      rxClk = 1'b0;
      repeat (OVS/2 - 1) @(negedge clk);
    end
  endtask

  task automatic skip(input int n);
    repeat (n * OVS) @(negedge clk);
  endtask

  // Driver pushes the sync count expected at the next sync event
  task automatic expectSync();
    expSync = (expSync + 1) % (1 << SW);
    expQ.push_back(expSync);
  endtask

  // Monitor: every syncStb must match a queued expectation (R2, R3)
  always @(negedge clk) begin
    if (rstN && chkPending) begin
      chk(int'(syncCnt) == chkVal, "R3 sync count after sync", int'(syncCnt), chkVal);
      chk(fineCnt == '0, "R2 fine reset at sync", int'(fineCnt), 0);
      chkPending = 1'b0;
    end
    if (rstN && syncStb) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected sync strobe", 1, 0);
      end else begin
        chkVal = expQ.pop_front();
        chkPending = 1'b1;
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(fineCnt == '0, "R9 fine reset", int'(fineCnt), 0);
    chk(syncCnt == '0, "R9 sync reset", int'(syncCnt), 0);
    chk(!clkLoss && !syncStb, "R9 flags low", int'(clkLoss), 0);
    rstN = 1'b1;
    rdAddr = 2'd1;
    #1 chk(rdData == '0, "R9 captured fine reset", int'(rdData), 0);

    // R1 priming edge then counting
    pulse(1);
    chk(fineCnt == '0, "R1 first edge only arms", int'(fineCnt), 0);
    pulse(5);
    chk(fineCnt == 5, "R1 fine counts edges", int'(fineCnt), 5);

    // R2 single missing pulse
    skip(1); expectSync(); pulse(1);
    pulse(3);
    chk(fineCnt == 3, "R2 fine after sync", int'(fineCnt), 3);
    chk(int'(syncCnt) == 1, "R2 sync count", int'(syncCnt), 1);

    // R4 two missing pulses
    skip(2);
    chk(clkLoss == 1'b1, "R4 loss flagged", int'(clkLoss), 1);
    pulse(1);
    chk(fineCnt == 3, "R4 fine untouched", int'(fineCnt), 3);
    chk(int'(syncCnt) == 1, "R4 sync untouched", int'(syncCnt), 1);
    chk(clkLoss == 1'b0, "R4 loss cleared", int'(clkLoss), 0);
    pulse(1);
    chk(fineCnt == 4, "R4 counting resumes", int'(fineCnt), 4);

    // R3 wrap through all ones to zero
    for (int k = 0; k < 15; k++) begin
      skip(1); expectSync(); pulse(1);
    end
    chk(syncCnt == '0, "R3 sync wrapped", int'(syncCnt), 0);
    pulse(7);

    // R5 capture, R6 read port
    @(negedge clk) capStb = 1'b1;
    @(negedge clk) capStb = 1'b0;
    pulse(2);
    rdAddr = 2'd1;
    #1 chk(rdData == 7, "R5 captured fine", int'(rdData), 7);
    rdAddr = 2'd2;
    #1 chk(rdData == 0, "R5 captured sync", int'(rdData), 0);
    skip(1); expectSync(); pulse(1);
    rdAddr = 2'd0;
    #1 chk(rdData == 1, "R6 live sync on address 0", int'(rdData), 1);
    rdAddr = 2'd2;
    #1 chk(rdData == 0, "R5 capture held across sync", int'(rdData), 0);
    rdAddr = 2'd3;
    #1 chk(rdData == 0, "R6 address 3 reads zero", int'(rdData), 0);

    // R7 gap ignored in timer mode, R8 default period
    @(negedge clk) modeSel = 1'b1;
    base = int'(fineCnt);
    skip(1); pulse(1);
    chk(int'(fineCnt) == base + 1, "R7 gap counted as edge", int'(fineCnt), base + 1);
    pulse(7990);
    chk(int'(syncCnt) == 1, "R8 no sync before default period", int'(syncCnt), 1);
    expectSync();
    pulse(250);
    chk(int'(syncCnt) == 2, "R8 sync at default period", int'(syncCnt), 2);

    // R7 programmed period of 200 cycles: two expiries in 60 pulses
    @(negedge clk) modeSel = 1'b0; timerPeriod = TW'(200);
    @(negedge clk) modeSel = 1'b1;
    expectSync(); expectSync();
    pulse(60);
    chk(int'(syncCnt) == 4, "R7 programmed timer syncs", int'(syncCnt), 4);
    @(negedge clk) modeSel = 1'b0;
    pulse(2);
    chk(expQ.size() == 0, "R2 all expected syncs seen", expQ.size(), 0);
    report();
  end

endmodule